// File: doc/BRIEF.md
# Memory-Mapped Status Light Controller

This block is a target on a 32-bit fetch-store bus. It drives a panel of sixteen status lights that has a global on/off control and a 4-bit brightness setting. Three adjacent register windows, each one data word (four byte addresses) wide, start at a base address. The first window turns the panel on and off and reports whether it is on. The second window holds the brightness code. The third window holds one bit for each light.

The block compares the address against every window, checks the operation and tests the data, all in the same cycle. Each access to a claimed address finishes with a single-cycle completion strobe in the cycle after the request, and read data appears alongside that strobe. The block ignores addresses outside its three windows, so another target or the bus fabric can answer them. The three register outputs feed the light drive circuits directly.

Top module: `status_light_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, the panel is off, the brightness code is 0, all lights are off, `done_o` is low and `rdata_o` is zero.
- R2: A store to any byte address from 100 to 103 turns the panel on when the stored word has any bit set, and turns it off when the stored word is zero. The new state appears in the cycle after the request.
- R3: A fetch from any address from 100 to 103 returns 1 when the panel is on and 0 when it is off.
- R4: A store to any address from 104 to 107 loads the brightness code from data bits 3:0, where 0 is dimmest and 15 is brightest. Data bits 31:4 are ignored.
- R5: A store to any address from 108 to 111 loads the light vector from data bits 15:0. Bit i lights light i when it is 1 and darkens it when it is 0. Data bits 31:16 are ignored.
- R6: A fetch from 104–107 returns the brightness code in bits 3:0. A fetch from 108–111 returns the light vector in bits 15:0. All other returned bits are zero.
- R7: A request to a claimed address raises `done_o` for exactly the next cycle and carries the fetch result on `rdata_o` in that cycle. Whenever `done_o` is low, `rdata_o` is zero.
- R8: A request to an address below 100 or above 111 gets no `done_o`, leaves the register state unchanged, and leaves `rdata_o` zero.
- R9: A fetch never changes the panel state, the brightness code or the lights.
- R10: With `req_i` low, the register state holds and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid for one cycle |
| we_i | input | 1 | 1 = store, 0 = fetch |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| done_o | output | 1 | Completion strobe for a claimed request |
| rdata_o | output | 32 | Fetch data, valid with `done_o` |
| disp_en_o | output | 1 | Panel enable |
| bright_o | output | 4 | Brightness code |
| lights_o | output | 16 | Per-light on/off vector |

## Verification
The bench uses the default parameters: base address 100, a 32-bit bus, sixteen lights and a 4-bit brightness code. Random addresses drawn from 94 to 117 hit every byte of each window, both outer edges of the claimed range, and the unclaimed addresses next to it. A smaller share of fully random 32-bit addresses probes the far address space. Data values are weighted toward zero and single-bit words, so the zero/nonzero enable test and the ignored upper data bits are both exercised.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int NUM_WIN = 3;
  typedef enum logic [1:0] {
    WIN_ENABLE = 2'd0,
    WIN_BRIGHT = 2'd1,
    WIN_LIGHTS = 2'd2
  } win_e;
endpackage

// File: rtl/slc_decode.sv
module slc_decode
  import slc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BYTES = 4,
  parameter int unsigned BASE_ADDR = 100
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_WIN-1:0] hit_o
);
  // one comparator pair per window, all evaluated in parallel
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR + k * WIN_BYTES);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR + (k + 1) * WIN_BYTES - 1);
    assign hit_o[k] = (addr_i >= LO) && (addr_i <= HI);
  end
endmodule

// File: rtl/slc_regs.sv
module slc_regs
  import slc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BRIGHT_W = 4,
  parameter int unsigned N_LIGHTS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WIN-1:0]  wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                disp_en_o,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic [N_LIGHTS-1:0] lights_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_en_o <= 1'b0;
      bright_o  <= '0;
      lights_o  <= '0;
    end else begin
      if (wr_i[WIN_ENABLE]) disp_en_o <= |wdata_i;
      if (wr_i[WIN_BRIGHT]) bright_o  <= wdata_i[BRIGHT_W-1:0];
      if (wr_i[WIN_LIGHTS]) lights_o  <= wdata_i[N_LIGHTS-1:0];
    end
  end
endmodule

// File: rtl/slc_readmux.sv
module slc_readmux
  import slc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BRIGHT_W = 4,
  parameter int unsigned N_LIGHTS = 16
) (
  input  logic [NUM_WIN-1:0]  sel_i,
  input  logic                disp_en_i,
  input  logic [BRIGHT_W-1:0] bright_i,
  input  logic [N_LIGHTS-1:0] lights_i,
  output logic [DATA_W-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_i[WIN_ENABLE]) rdata_o = DATA_W'(disp_en_i);
    if (sel_i[WIN_BRIGHT]) rdata_o = DATA_W'(bright_i);
    if (sel_i[WIN_LIGHTS]) rdata_o = DATA_W'(lights_i);
  end
endmodule

// File: rtl/status_light_ctrl.sv
module status_light_ctrl
  import slc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 100,
  parameter int unsigned BRIGHT_W  = 4,
  parameter int unsigned N_LIGHTS  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                disp_en_o,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic [N_LIGHTS-1:0] lights_o
);
  localparam int unsigned WIN_BYTES = DATA_W / 8;

  logic [NUM_WIN-1:0] hit;
  logic [NUM_WIN-1:0] wr;
  logic [NUM_WIN-1:0] rd;
  logic [DATA_W-1:0]  rd_mux;
  logic               claim;

  slc_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_i(addr_i), .hit_o(hit)
  );

  assign claim = req_i && (|hit);
  assign wr    = (req_i &&  we_i) ? hit : '0;
  assign rd    = (req_i && !we_i) ? hit : '0;

  slc_regs #(
    .DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W), .N_LIGHTS(N_LIGHTS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(wdata_i),
    .disp_en_o(disp_en_o), .bright_o(bright_o), .lights_o(lights_o)
  );

  slc_readmux #(
    .DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W), .N_LIGHTS(N_LIGHTS)
  ) u_readmux (
    .sel_i(rd), .disp_en_i(disp_en_o), .bright_i(bright_o),
    .lights_i(lights_o), .rdata_o(rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o  <= claim;
      rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_ADDR = 100,
  parameter int unsigned BRIGHT_W  = 4,
  parameter int unsigned N_LIGHTS  = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                done_o,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                disp_en_o,
  input logic [BRIGHT_W-1:0] bright_o,
  input logic [N_LIGHTS-1:0] lights_o
);
  localparam int unsigned WB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(BASE_ADDR + WB);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(BASE_ADDR + 2 * WB);
  localparam logic [ADDR_W-1:0] AE = ADDR_W'(BASE_ADDR + 3 * WB);

  logic in_en, in_br, in_li, in_any;
  assign in_en  = addr_i >= A0 && addr_i < A1;
  assign in_br  = addr_i >= A1 && addr_i < A2;
  assign in_li  = addr_i >= A2 && addr_i < AE;
  assign in_any = addr_i >= A0 && addr_i < AE;

  AST_DONE_AFTER_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && in_any |=> done_o); // R7
  AST_NO_DONE_UNCLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && in_any) |=> !done_o); // R8
  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> rdata_o == '0); // R7
  AST_ENABLE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_en |=> disp_en_o == (|$past(wdata_i))); // R2
  AST_STATUS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && in_en |=> rdata_o == DATA_W'(disp_en_o)); // R3
  AST_BRIGHT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_br |=> bright_o == $past(wdata_i[BRIGHT_W-1:0])); // R4
  AST_LIGHTS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_li |=> lights_o == $past(wdata_i[N_LIGHTS-1:0])); // R5
  AST_FETCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> $stable(disp_en_o) && $stable(bright_o) && $stable(lights_o)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(disp_en_o) && $stable(bright_o) && $stable(lights_o)); // R10
  AST_UNCLAIMED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !in_any |=> $stable(disp_en_o) && $stable(bright_o) && $stable(lights_o)); // R8
endmodule

bind status_light_ctrl slc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
  .BRIGHT_W(BRIGHT_W), .N_LIGHTS(N_LIGHTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .rdata_o(rdata_o),
  .disp_en_o(disp_en_o), .bright_o(bright_o), .lights_o(lights_o)
);

// File: tb/tb_status_light_ctrl.sv
module tb_status_light_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic        disp_en_o;
  logic [3:0]  bright_o;
  logic [15:0] lights_o;

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 1'b0;

  logic        m_disp = 1'b0;
  logic [3:0]  m_bright = '0;
  logic [15:0] m_lights = '0;

  always #4 clk_i = ~clk_i;

  status_light_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .rdata_o(rdata_o),
    .disp_en_o(disp_en_o), .bright_o(bright_o), .lights_o(lights_o)
  );

  function automatic bit f_claim(logic [31:0] a);
    return a >= 32'd100 && a <= 32'd111;
  endfunction

  function automatic logic [31:0] f_rdata(logic we, logic [31:0] a);
    if (we || !f_claim(a)) return 32'd0;
    if (a <= 32'd103) return {31'd0, m_disp};
    if (a <= 32'd107) return {28'd0, m_bright};
    return {16'd0, m_lights};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " enable"}, {31'd0, disp_en_o}, {31'd0, m_disp});
    check({tag, " bright"}, {28'd0, bright_o}, {28'd0, m_bright});
    check({tag, " lights"}, {16'd0, lights_o}, {16'd0, m_lights});
  endtask

  // drive at negedge, the DUT samples at the next posedge, sample at the following negedge
  task automatic bus_op(logic we, logic [31:0] a, logic [31:0] d);
    logic [31:0] exp_rd;
    bit          exp_done;
    exp_done = f_claim(a);
    exp_rd   = f_rdata(we, a);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    if (we && a >= 32'd100 && a <= 32'd103) m_disp   = |d;
    if (we && a >= 32'd104 && a <= 32'd107) m_bright = d[3:0];
    if (we && a >= 32'd108 && a <= 32'd111) m_lights = d[15:0];
    @(negedge clk_i);
    req_i = 1'b0;
    check(exp_done ? "R7 done" : "R8 done", {31'd0, done_o}, {31'd0, exp_done});
    check(we ? "R7 rdata" : "R3/R6 rdata", rdata_o, exp_rd);
    check_state(exp_done ? (we ? "R2/R4/R5" : "R9") : "R8");
  endtask

  task automatic idle_check(string tag);
    @(negedge clk_i);
    check({tag, " done"}, {31'd0, done_o}, 32'd0);
    check({tag, " rdata"}, rdata_o, 32'd0);
    check_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 rdata", rdata_o, 32'd0);
    check_state("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    bus_op(1'b1, 32'd103, 32'h8000_0000);  // R2 top bit only turns on
    bus_op(1'b0, 32'd101, 32'h0);          // R3 reads 1
    bus_op(1'b1, 32'd100, 32'h0);          // R2 zero turns off
    bus_op(1'b0, 32'd102, 32'h0);          // R3 reads 0
    bus_op(1'b1, 32'd104, 32'hFFFF_FFF3);  // R4 upper bits ignored
    bus_op(1'b1, 32'd107, 32'h0000_000F);  // R4 brightest
    bus_op(1'b0, 32'd105, 32'h0);          // R6
    bus_op(1'b1, 32'd108, 32'hABCD_1234);  // R5 upper bits ignored
    bus_op(1'b0, 32'd111, 32'h0);          // R6
    bus_op(1'b1, 32'd112, 32'hFFFF_FFFF);  // R8 just above
    bus_op(1'b1, 32'd99,  32'hFFFF_FFFF);  // R8 just below
    bus_op(1'b0, 32'd99,  32'h0);          // R8 fetch unclaimed
    bus_op(1'b1, 32'd101, 32'h0000_0001);  // R2
    idle_check("R7/R10 idle");             // done lasts one cycle
    wdata_i = 32'h0; addr_i = 32'd100; we_i = 1'b1;  // req low: store bits present but ignored
    idle_check("R10 ignored");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, d;
      logic        w;
      w = 1'($urandom % 2);
      if ($urandom % 8 == 0) a = $urandom;
      else a = 32'd94 + ($urandom % 24);
      case ($urandom % 4)
        0: d = 32'd0;
        1: d = 32'd1 << ($urandom % 32);
        default: d = $urandom;
      endcase
      bus_op(w, a, d);
      if ($urandom % 16 == 0) idle_check("R7/R10 gap");
    end

    rst_ni = 1'b0;
    m_disp = 1'b0; m_bright = '0; m_lights = '0;
    #1;
    check("R1 async done", {31'd0, done_o}, 32'd0);
    check_state("R1 async");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule